// File: doc/BRIEF.md
# Auto-Reload Timer Baud Generator

An 8-bit up-counting timer drives a serial baud clock. Software loads a start value into the counter. The same write also stores that value as the reload value. The timer counts on a selectable prescaled strobe taken from the system clock. When the count passes its top value it restarts from the reload value. Each restart gives a one-cycle overflow pulse and flips a toggle flip-flop. The toggle output is the baud clock, so the baud rate is the count rate divided by (256 − D), then by two.

A control write sets a 3-bit clock-select field and a run bit. The reload value can also be written on its own, without changing the running count. Everything runs on one system clock. Reset is synchronous and clears every register, which also leaves the timer stopped. No data stream crosses the edge of this block, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `baud_timer`

## Requirements
- R1: When `cnt_wr` is high at a clock edge, both `cnt_q` and `rld_q` take `wr_data` at that edge. This write takes priority over counting and over overflow in the same cycle.
- R2: When `rld_wr` is high and `cnt_wr` is low, `rld_q` takes `wr_data` and the count is unaffected. The count keeps its value, or keeps counting if the timer is running.
- R3: A control write latches `wr_data[3]` as the run bit. Counting starts with the edge after a write of 1. After a write of 0, `cnt_q` holds its value.
- R4: With reload value D, `cnt_q` counts up by one per count tick. After 255 it goes to D, so overflows occur every (256 − D) count ticks.
- R5: A control write latches `wr_data[2:0]` as select value s. A count tick then occurs once every 2^s system clocks (s = 0 means every clock, up to s = 7 meaning every 128 clocks).
- R6: `ovf_pulse` is high for exactly the one cycle in which `cnt_q` has just wrapped from 255 to the reload value. The only exception is D = 255 with s = 0, where the pulse stays high.
- R7: `baud_clk` flips on every overflow and at no other time. `baud_rise` is high for the one cycle in which `baud_clk` has just become 1.
- R8: While `rst` is high, `cnt_q`, `rld_q`, `ovf_pulse`, `baud_clk` and `baud_rise` go to 0 and the run bit clears. After reset the count stays at 0 until a run write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_wr | input | 1 | Write `wr_data` to counter and reload register |
| rld_wr | input | 1 | Write `wr_data` to reload register only |
| ctl_wr | input | 1 | Write control: bit 3 run, bits 2:0 clock select |
| wr_data | input | 8 | Bus write data |
| cnt_q | output | 8 | Current count |
| rld_q | output | 8 | Current reload value |
| ovf_pulse | output | 1 | One-cycle overflow flag |
| baud_clk | output | 1 | Overflow rate divided by two |
| baud_rise | output | 1 | One-cycle strobe on each rising edge of `baud_clk` |

## Verification
The assertions assume synchronous, glitch-free write strobes. They also assume that a reload-only write is not expected to take effect when a counter write is high in the same cycle. The assertions tie the wrap check to the previous count being 255, not to the reload value, because a reload write can land on the same edge as an overflow. The bench drives every write strobe for exactly one cycle at the falling edge and never raises two strobes together. Each timing measurement runs between two overflow pulses, so the prescaler's free-running phase does not affect the measured intervals.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int CNT_W = 8;
  localparam int SEL_W = 3;
  localparam int RUN_BIT = SEL_W;

  typedef struct packed {
    logic             run;
    logic [SEL_W-1:0] sel;
  } bt_ctrl_t;
endpackage

// File: rtl/bt_prescale.sv
module bt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int PRE_W = NSEL - 1;

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  strobe;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  assign strobe[0] = 1'b1;
  for (genvar i = 1; i < NSEL; i++) begin : g_strobe
    assign strobe[i] = &pre_q[i-1:0];
  end

  assign tick = strobe[sel];
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_wr,
  input  logic             rld_wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] rld_q,
  output logic             ovf_evt,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic step;
  assign step    = run && tick && !cnt_wr;
  assign ovf_evt = step && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt;
      if (cnt_wr) begin
        cnt_q <= wr_data;
        rld_q <= wr_data;
      end else begin
        if (rld_wr) rld_q <= wr_data;
        if (ovf_evt)   cnt_q <= rld_q;
        else if (step) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bt_halver.sv
module bt_halver (
  input  logic clk,
  input  logic rst,
  input  logic ovf_evt,
  output logic baud_q,
  output logic rise_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      baud_q <= baud_q ^ ovf_evt;
      rise_q <= ovf_evt && !baud_q;
    end
  end
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import bt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_wr,
  input  logic          rld_wr,
  input  logic          ctl_wr,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] rld_q,
  output logic          ovf_pulse,
  output logic          baud_clk,
  output logic          baud_rise
);
  logic          run_q;
  logic [SW-1:0] sel_q;
  logic          tick;
  logic          ovf_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      sel_q <= '0;
    end else if (ctl_wr) begin
      run_q <= wr_data[SW];
      sel_q <= wr_data[SW-1:0];
    end
  end

  bt_prescale #(.SEL_W(SW)) u_pre (
    .clk(clk), .rst(rst), .sel(sel_q), .tick(tick)
  );

  bt_counter #(.CNT_W(CW)) u_cnt (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
    .wr_data(wr_data), .run(run_q), .tick(tick),
    .cnt_q(cnt_q), .rld_q(rld_q), .ovf_evt(ovf_evt), .ovf_q(ovf_pulse)
  );

  bt_halver u_half (
    .clk(clk), .rst(rst), .ovf_evt(ovf_evt),
    .baud_q(baud_clk), .rise_q(baud_rise)
  );
endmodule

// File: rtl/baud_timer_chk.sv
module baud_timer_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cnt_wr,
  input logic          rld_wr,
  input logic [CW-1:0] wr_data,
  input logic          run_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] rld_q,
  input logic          ovf_pulse,
  input logic          baud_clk,
  input logic          baud_rise
);
  p_load_both_r1: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(wr_data)) && (rld_q == $past(wr_data)));

  p_rld_only_r2: assert property (@(posedge clk) disable iff (rst)
    (rld_wr && !cnt_wr) |=> rld_q == $past(wr_data));

  p_halt_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cnt_wr) |=> $stable(cnt_q));

  p_wrap_from_top_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> $past(cnt_q) == {CW{1'b1}});

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q || cnt_wr) |=> !ovf_pulse);

  p_baud_flip_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> baud_clk != $past(baud_clk));

  p_baud_still_r7: assert property (@(posedge clk) disable iff (rst)
    !ovf_pulse |-> $stable(baud_clk));

  p_rise_valid_r7: assert property (@(posedge clk) disable iff (rst)
    baud_rise |-> (baud_clk && ovf_pulse));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cnt_q == '0) && (rld_q == '0) && !ovf_pulse && !baud_clk && !baud_rise && !run_q);
endmodule

bind baud_timer baud_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .rld_wr(rld_wr), .wr_data(wr_data),
  .run_q(run_q), .cnt_q(cnt_q), .rld_q(rld_q), .ovf_pulse(ovf_pulse),
  .baud_clk(baud_clk), .baud_rise(baud_rise)
);

// File: tb/tb_baud_timer.sv
module tb_baud_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_wr = 1'b0, rld_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_q, rld_q;
  logic       ovf_pulse, baud_clk, baud_rise;

  int n_total = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  baud_timer dut (
    .clk(clk), .rst(rst), .cnt_wr(cnt_wr), .rld_wr(rld_wr), .ctl_wr(ctl_wr),
    .wr_data(wr_data), .cnt_q(cnt_q), .rld_q(rld_q), .ovf_pulse(ovf_pulse),
    .baud_clk(baud_clk), .baud_rise(baud_rise)
  );

  // sel, reload D, expected overflow period (256-D)*2^sel
  localparam int NV = 7;
  localparam int VEC [NV][3] = '{
    '{0, 250,   6}, '{0, 255,   1}, '{1, 252,   8}, '{3, 254,  16},
    '{7, 255, 128}, '{0,   0, 256}, '{2, 200, 224}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all write tasks are entered at a falling edge and return at the next one
  task automatic wr_cnt(input logic [7:0] d);
    cnt_wr = 1'b1; wr_data = d;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wr_rld(input logic [7:0] d);
    rld_wr = 1'b1; wr_data = d;
    @(negedge clk); rld_wr = 1'b0;
  endtask

  task automatic wr_ctl(input bit run, input int sel);
    ctl_wr = 1'b1; wr_data = {4'b0, run, sel[2:0]};
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wait_ovf(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ovf_pulse) begin seen = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    bit seen;
    logic b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(cnt_q == 0 && rld_q == 0, "R8 reset regs", cnt_q, 0);
    chk(!ovf_pulse && !baud_clk && !baud_rise, "R8 reset flags",
        {ovf_pulse, baud_clk, baud_rise}, 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      int n;
      wr_ctl(1'b0, 0);
      wr_cnt(VEC[v][1][7:0]);
      wr_ctl(1'b1, VEC[v][0]);
      wait_ovf(seen);
      chk(seen, "R6 first overflow seen", seen, 1);
      chk(baud_rise == baud_clk, "R7 rise strobe", baud_rise, baud_clk);
      b0 = baud_clk;
      n = 0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk); n++;
        if (ovf_pulse) break;
      end
      chk(n == VEC[v][2], "R4 R5 overflow period", n, VEC[v][2]);
      chk(baud_clk != b0, "R7 baud toggled", baud_clk, !b0);
    end

    // R1: counter write loads both
    wr_ctl(1'b0, 0);
    wr_cnt(8'h42);
    chk(cnt_q == 8'h42 && rld_q == 8'h42, "R1 load both", {cnt_q, rld_q}, 16'h4242);

    // R3: run and halt
    wr_cnt(8'd10);
    wr_ctl(1'b1, 0);
    chk(cnt_q == 8'd10, "R3 no count on run write edge", cnt_q, 10);
    repeat (3) @(negedge clk);
    chk(cnt_q == 8'd13, "R3 counting", cnt_q, 13);
    wr_ctl(1'b0, 0);
    chk(cnt_q == 8'd14, "R3 last step", cnt_q, 14);
    repeat (5) @(negedge clk);
    chk(cnt_q == 8'd14, "R3 halted hold", cnt_q, 14);

    // R2: reload-only write while running
    wr_cnt(8'd100);
    wr_ctl(1'b1, 0);
    wr_rld(8'd7);
    chk(cnt_q == 8'd101, "R2 count unaffected", cnt_q, 101);
    chk(rld_q == 8'd7, "R2 reload written", rld_q, 7);

    // R4 and R6: wrap value and single-cycle pulse
    wr_ctl(1'b0, 0);
    wr_cnt(8'd200);
    wr_ctl(1'b1, 0);
    wait_ovf(seen);
    chk(seen && cnt_q == 8'd200, "R4 wrap to reload", cnt_q, 200);
    @(negedge clk);
    chk(!ovf_pulse, "R6 pulse one cycle", ovf_pulse, 0);

    // R8: reset while running
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_q == 0 && rld_q == 0 && !baud_clk, "R8 reset mid run", cnt_q, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(cnt_q == 0 && !ovf_pulse, "R8 stopped after reset", cnt_q, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule